// File: doc/BRIEF.md
# Piecewise Quadratic Sigmoid Approximator

This block evaluates a hardware-friendly stand-in for the logistic sigmoid on a signed fixed-point net input. It does not compute an exponential. The input range is split into four regions:

- Below -4.0 the output is a flat 0.
- Above +4.0 the output is a flat 1.
- Between -4.0 and 0 the output is one squared term.
- Between 0 and +4.0 the output is the mirror image of that squared term.

Both the input and the output carry 13 fractional bits, so the value 1.0 is encoded as 8192.

One input may be offered on every clock cycle, qualified by a valid strobe. The result appears with its own valid strobe exactly two cycles later.

The first stage works out the region and the square, and registers both. The second stage forms and clamps the activation. A neuron datapath places the unit directly after its weighted-sum accumulator.

Top module: `sig_quad_act`

## Requirements
- R1: While reset is held low, `act_vld_o` is 0 and `act_o` is 0.
- R2: `act_vld_o` is high in a cycle exactly when `net_vld_i` was high two rising edges earlier. It is never high otherwise.
- R3: An accepted input of 32768 (+4.0) or more gives an output of exactly 8192.
- R4: An accepted input of -32768 (-4.0) or less gives an output of exactly 0.
- R5: For an input x with 0 <= x < 32768, let q = floor(x/4) and t = 8192 - q. The output is 8192 - floor(floor(t*t / 8192) / 2).
- R6: For an input x with -32768 < x < 0, let q = floor(x/4), rounded toward minus infinity, and t = 8192 + q. The output is floor(floor(t*t / 8192) / 2).
- R7: An input of exactly 0 gives 4096 (0.5).
- R8: Every valid output lies in the range 0 to 8192.
- R9: Inputs on consecutive cycles are all accepted. Results leave in the same order, one per cycle.
- R10: While `act_vld_o` is low, `act_o` holds the last valid result. An idle input value does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| net_vld_i | input | 1 | Qualifies `net_i` this cycle |
| net_i | input | IN_W (18) | Signed net input, 13 fractional bits |
| act_vld_o | output | 1 | Qualifies `act_o` |
| act_o | output | FRAC_W+1 (14) | Unsigned activation, 8192 = 1.0 |

## Verification
A wrong stored region code shows up at the ports within two cycles. It produces an output stuck at 0 or 8192 where a curved value was due, or a value on the wrong side of 4096. A damaged square register shows up as a one-cycle mismatch against the integer model, most clearly near ±4.0 and at zero, where the expected values are exact. A slip in the valid pipeline shows up in the very next cycle as a strobe or a held value that does not match the model.

// File: rtl/sig_pkg.sv
package sig_pkg;
    typedef enum logic [1:0] {
        RGN_LOW  = 2'd0,
        RGN_NEG  = 2'd1,
        RGN_POS  = 2'd2,
        RGN_HIGH = 2'd3
    } region_t;
endpackage

// File: rtl/sig_sq_stage.sv
module sig_sq_stage
    import sig_pkg::*;
#(
    parameter int IN_W   = 18,
    parameter int FRAC_W = 13,
    localparam int SQ_W  = FRAC_W + 2
) (
    input  logic signed [IN_W-1:0] x_i,
    output region_t                region_o,
    output logic [SQ_W-1:0]        sq_o
);
    localparam logic signed [IN_W-1:0] LIM_P = IN_W'(4 << FRAC_W);
    localparam logic signed [IN_W-1:0] LIM_N = -LIM_P;
    localparam logic signed [IN_W:0]   ONE_S = (IN_W+1)'(1 << FRAC_W);

    logic signed [IN_W-1:0]   quarter;
    logic signed [IN_W:0]     q_ext;
    logic signed [IN_W:0]     t_s;
    logic [FRAC_W:0]          t_u;
    logic [2*FRAC_W+1:0]      prod;

    always_comb begin
        quarter = x_i >>> 2;
        q_ext   = {quarter[IN_W-1], quarter};
        if (x_i >= LIM_P) begin
            region_o = RGN_HIGH;
            t_s      = '0;
        end else if (x_i <= LIM_N) begin
            region_o = RGN_LOW;
            t_s      = '0;
        end else if (x_i[IN_W-1]) begin
            region_o = RGN_NEG;
            t_s      = ONE_S + q_ext;
        end else begin
            region_o = RGN_POS;
            t_s      = ONE_S - q_ext;
        end
        t_u  = t_s[FRAC_W:0];
        prod = t_u * t_u;
        sq_o = prod[2*FRAC_W+1:FRAC_W];
    end
endmodule

// File: rtl/sig_mix_stage.sv
module sig_mix_stage
    import sig_pkg::*;
#(
    parameter int FRAC_W = 13,
    localparam int SQ_W  = FRAC_W + 2,
    localparam int OUT_W = FRAC_W + 1
) (
    input  region_t          region_i,
    input  logic [SQ_W-1:0]  sq_i,
    output logic [OUT_W-1:0] y_o
);
    localparam logic [SQ_W-1:0] ONE = SQ_W'(1 << FRAC_W);

    logic [SQ_W-1:0] half;
    logic [SQ_W-1:0] raw;

    always_comb begin
        half = sq_i >> 1;
        unique case (region_i)
            RGN_HIGH: raw = ONE;
            RGN_POS:  raw = (half > ONE) ? '0 : ONE - half;
            RGN_NEG:  raw = half;
            default:  raw = '0;
        endcase
        y_o = (raw > ONE) ? ONE[OUT_W-1:0] : raw[OUT_W-1:0];
    end
endmodule

// File: rtl/sig_quad_act.sv
module sig_quad_act
    import sig_pkg::*;
#(
    parameter int IN_W   = 18,
    parameter int FRAC_W = 13,
    localparam int SQ_W  = FRAC_W + 2,
    localparam int OUT_W = FRAC_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   net_vld_i,
    input  logic signed [IN_W-1:0] net_i,
    output logic                   act_vld_o,
    output logic [OUT_W-1:0]       act_o
);
    localparam logic signed [IN_W-1:0] LIM_P = IN_W'(4 << FRAC_W);
    localparam logic signed [IN_W-1:0] LIM_N = -LIM_P;
    localparam logic [OUT_W-1:0]       ONE   = OUT_W'(1 << FRAC_W);
    localparam logic [OUT_W-1:0]       HALF  = OUT_W'(1 << (FRAC_W - 1));

    typedef struct packed {
        logic             v1;
        region_t          r1;
        logic [SQ_W-1:0]  sq1;
        logic             v2;
        logic [OUT_W-1:0] y2;
    } pipe_t;

    pipe_t            pipe_d, pipe_q;
    region_t          rgn_c;
    logic [SQ_W-1:0]  sq_c;
    logic [OUT_W-1:0] y_c;

    sig_sq_stage #(.IN_W(IN_W), .FRAC_W(FRAC_W)) sq_i (
        .x_i      (net_i),
        .region_o (rgn_c),
        .sq_o     (sq_c)
    );

    sig_mix_stage #(.FRAC_W(FRAC_W)) mix_i (
        .region_i (pipe_q.r1),
        .sq_i     (pipe_q.sq1),
        .y_o      (y_c)
    );

    always_comb begin
        pipe_d    = pipe_q;
        pipe_d.v1 = net_vld_i;
        if (net_vld_i) begin
            pipe_d.r1  = rgn_c;
            pipe_d.sq1 = sq_c;
        end
        pipe_d.v2 = pipe_q.v1;
        if (pipe_q.v1) begin
            pipe_d.y2 = y_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign act_vld_o = pipe_q.v2;
    assign act_o     = pipe_q.y2;

    AST_LAT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        net_vld_i |-> ##2 act_vld_o); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !net_vld_i |-> ##2 !act_vld_o); // R2
    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (net_vld_i && net_i >= LIM_P) |-> ##2 (act_o == ONE)); // R3
    AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (net_vld_i && net_i <= LIM_N) |-> ##2 (act_o == '0)); // R4
    AST_ZERO_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (net_vld_i && net_i == '0) |-> ##2 (act_o == HALF)); // R7
    AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        act_vld_o |-> (act_o <= ONE)); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !act_vld_o |-> $stable(act_o)); // R10
endmodule

// File: tb/sig_quad_act_tb_top.sv
module sig_quad_act_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              net_vld_i = 1'b0;
    logic signed [17:0] net_i = '0;
    logic              act_vld_o;
    logic [13:0]       act_o;

    int checks = 0;
    int errors = 0;
    bit m1_v = 0, m2_v = 0;
    int m1_y = 0, hold_y = 0;
    string m1_tag = "R2", m2_tag = "R2";

    always #2 clk = ~clk;

    sig_quad_act dut_i (
        .clk(clk), .rst_n(rst_n), .net_vld_i(net_vld_i), .net_i(net_i),
        .act_vld_o(act_vld_o), .act_o(act_o)
    );

    function automatic int ref_y(int x);
        int q, t;
        if (x >= 32768) return 8192;
        if (x <= -32768) return 0;
        q = x >>> 2;
        if (x >= 0) begin
            t = 8192 - q;
            return 8192 - (((t * t) >>> 13) >>> 1);
        end
        t = 8192 + q;
        return ((t * t) >>> 13) >>> 1;
    endfunction

    function automatic string ref_tag(int x);
        if (x == 0) return "R7";
        if (x >= 32768) return "R3";
        if (x <= -32768) return "R4";
        if (x > 0) return "R5";
        return "R6";
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(bit v, int x);
        @(negedge clk);
        check("R2/R9 valid", int'(act_vld_o), int'(m2_v));
        if (m2_v) begin
            check(m2_tag, int'(act_o), hold_y);
            checks++;
            if (act_o > 14'd8192) begin
                errors++;
                $display("FAIL R8 actual=%0d expected<=8192", act_o);
            end
        end else begin
            check("R10 hold", int'(act_o), hold_y);
        end
        m2_v = m1_v;
        m2_tag = m1_tag;
        if (m1_v) hold_y = m1_y;
        m1_v = v;
        m1_y = ref_y(x);
        m1_tag = ref_tag(x);
        net_vld_i = v;
        net_i = 18'(x);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int edges [15] = '{-131072, -40000, -32769, -32768, -32767, -5, -4, -3, -1,
                           0, 1, 3, 4, 32767, 32768};
        repeat (3) @(negedge clk);
        check("R1 valid", int'(act_vld_o), 0);
        check("R1 data", int'(act_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        foreach (edges[i]) step(1'b1, edges[i]);
        step(1'b1, 32769);
        step(1'b1, 131071);
        step(1'b0, 0);
        step(1'b0, -20000);
        step(1'b0, 30000);
        for (int x = -40000; x <= 40000; x += 37) begin
            if (((x + 40000) / 37) % 9 == 4) step(1'b0, -x);
            else step(1'b1, x);
        end
        step(1'b1, 0);
        step(1'b0, 12345);
        step(1'b0, 0);
        step(1'b0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule